// File: doc/BRIEF.md
# Cubic Spline DC-Bias Generator

This block makes one 16-bit DAC code on every clock from a cubic polynomial in time. It has no multipliers. Four 48-bit accumulators form a forward-difference cascade: each accumulator adds the one above it on every cycle. The output code is the integer part of the lowest accumulator.

A host loads the coefficients as nine 16-bit words, using a write strobe and a word index. The words go into a shadow bank and do not change the running waveform. A trigger pulse copies the whole shadow bank into the accumulators in a single cycle and restarts the curve from step zero. Without a trigger, the channel keeps producing its current curve. The shadow bank keeps its contents, so a later trigger with no new writes replays the same curve.

The coefficient formats, in output LSB units, are:

| Coefficient | Width | Format |
|---|---|---|
| a0 | 16 bits | integer |
| a1 | 32 bits | 16 fractional bits |
| a2 | 48 bits | 32 fractional bits |
| a3 | 48 bits | 32 fractional bits |

All values are two's complement. The host applies the factors of 2 and 6 that the second and third orders need.

Top module: `spline_dcbias`

## Requirements
- R1: After reset the sample output is 0 and every shadow word is 0. A trigger with no writes after reset therefore gives a constant output of 0.
- R2: A write (wrEn high) stores wrData into the shadow word selected by wrAddr, with this map:
  - index 0: a0
  - indices 1 and 2: a1 bits 15:0 and 31:16
  - indices 3, 4 and 5: a2 bits 15:0, 31:16 and 47:32
  - indices 6, 7 and 8: a3 bits 15:0, 31:16 and 47:32
- R3: A write with wrAddr from 9 to 15 changes no shadow word.
- R4: Shadow writes without a trigger leave the running output unchanged.
- R5: Let the trigger be high at clock edge k. The sample registered at edge k+1 equals the a0 held in the shadow bank just before edge k.
- R6: At edge k+1+n, the sample equals bits 47:32 of the value below, taken modulo 2^48:
  - a0·2^32 + a1·2^16·n + a2·n(n-1)/2 + a3·n(n-1)(n-2)/6
- R7: The accumulators wrap modulo 2^48 with no saturation. For example, with a0 = 0x7FF0 and a1 = 0x0001_0000, the sample reaches 0x8000 sixteen cycles after the first sample.
- R8: When a write and a trigger fall on the same edge, the trigger loads the shadow contents from before that write, and the written word is kept for the next trigger.
- R9: The shadow bank keeps its contents through a trigger. A second trigger with no writes in between restarts the identical curve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Coefficient word write strobe |
| wrAddr | input | 4 | Word index, 0 to 8 valid |
| wrData | input | 16 | Coefficient word |
| trig | input | 1 | Load shadow bank and restart curve |
| sample | output | 16 | DAC code, two's complement |

## Verification
- **Shadow writes** land on the edge where wrEn is seen.
- **First sample:** the accumulators load on the trigger edge. The first sample, equal to a0, appears one edge later because of the output register. The bench lowers the trigger at the next falling edge and reads that sample at the falling edge after it.
- **Later samples:** each following falling edge shows the next step of the curve. The expected value comes from the closed-form sum with binomial weights, in 64-bit arithmetic.
- **Checks on ignored writes** (ignored indices, writes without a trigger) read the running output, or replay the shadow bank through a further trigger.

// File: rtl/spline_dcbias_pkg.sv
package spline_dcbias_pkg;
  parameter int WORD_W = 16;
  parameter int NUM_WORDS = 9;
  localparam int ACC_W = 3 * WORD_W;

  typedef struct packed {
    logic [NUM_WORDS-1:0] wordWe;
    logic load;
  } ctlStrobes_t;
endpackage

// File: rtl/spline_dcbias_ctl.sv
module spline_dcbias_ctl
  import spline_dcbias_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              trig,
  output ctlStrobes_t       strobes
);
  // One-hot word enable per shadow slot; indices past the bank match nothing.
  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_dec
    assign strobes.wordWe[i] = wrEn && (wrAddr == ADDR_W'(i));
  end
  assign strobes.load = trig;
endmodule

// File: rtl/spline_dcbias_dp.sv
module spline_dcbias_dp
  import spline_dcbias_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  ctlStrobes_t                 strobes,
  input  logic [WORD_W-1:0]           wrData,
  output logic [NUM_WORDS*WORD_W-1:0] shadowFlat,
  output logic [WORD_W-1:0]           sample
);
  localparam int ORDERS = 4;

  logic [WORD_W-1:0] shadow [NUM_WORDS];
  logic [ACC_W-1:0]  loadVal [ORDERS];
  logic [ACC_W-1:0]  acc [ORDERS];

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_shadow
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) shadow[i] <= '0;
      else if (strobes.wordWe[i]) shadow[i] <= wrData;
    end
    assign shadowFlat[i*WORD_W +: WORD_W] = shadow[i];
  end

  // Align every order to the common 48-bit format with 32 fractional bits.
  assign loadVal[0] = {shadow[0], {(2*WORD_W){1'b0}}};
  assign loadVal[1] = {shadow[2], shadow[1], {WORD_W{1'b0}}};
  assign loadVal[2] = {shadow[5], shadow[4], shadow[3]};
  assign loadVal[3] = {shadow[8], shadow[7], shadow[6]};

  for (genvar o = 0; o < ORDERS; o++) begin : g_acc
    if (o < ORDERS - 1) begin : g_sum
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) acc[o] <= '0;
        else if (strobes.load) acc[o] <= loadVal[o];
        else acc[o] <= acc[o] + acc[o+1];
      end
    end else begin : g_top
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) acc[o] <= '0;
        else if (strobes.load) acc[o] <= loadVal[o];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sample <= '0;
    else sample <= acc[0][ACC_W-1 -: WORD_W];
  end
endmodule

// File: rtl/spline_dcbias.sv
module spline_dcbias
  import spline_dcbias_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [3:0]  wrAddr,
  input  logic [15:0] wrData,
  input  logic        trig,
  output logic [15:0] sample
);
  ctlStrobes_t strobes;
  logic [NUM_WORDS*WORD_W-1:0] shadowFlat;

  spline_dcbias_ctl #(.ADDR_W(4)) uCtl (
    .wrEn(wrEn), .wrAddr(wrAddr), .trig(trig), .strobes(strobes)
  );

  spline_dcbias_dp uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .shadowFlat(shadowFlat), .sample(sample)
  );
endmodule

// File: rtl/spline_dcbias_chk.sv
module spline_dcbias_chk
  import spline_dcbias_pkg::*;
(
  input logic                        clk,
  input logic                        rstN,
  input logic                        wrEn,
  input logic [3:0]                  wrAddr,
  input logic [15:0]                 wrData,
  input logic                        trig,
  input logic [15:0]                 sample,
  input logic [NUM_WORDS*WORD_W-1:0] shadowFlat
);
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr < 4'(NUM_WORDS)) |=>
      shadowFlat[int'($past(wrAddr))*WORD_W +: WORD_W] == $past(wrData)); // R2

  AST_BAD_INDEX_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr >= 4'(NUM_WORDS)) |=> $stable(shadowFlat)); // R3

  AST_IDLE_SHADOW_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(shadowFlat)); // R9

  AST_FIRST_SAMPLE_A0: assert property (@(posedge clk) disable iff (!rstN)
    trig |=> ##1 (sample == $past(shadowFlat[WORD_W-1:0], 2))); // R5
endmodule

bind spline_dcbias spline_dcbias_chk uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .trig(trig), .sample(sample), .shadowFlat(shadowFlat)
);

// File: tb/spline_dcbias_test.sv
module spline_dcbias_test;
  localparam int CLK_PERIOD = 10;
  localparam int SWEEP = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        trig = 1'b0;
  logic [15:0] sample;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  spline_dcbias uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .trig(trig), .sample(sample)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] expSample(longint a0, longint a1,
                                            longint a2, longint a3, int n);
    longint nn = longint'(n);
    longint c2 = nn * (nn - 1) / 2;
    longint c3 = nn * (nn - 1) * (nn - 2) / 6;
    longint acc = (a0 <<< 32) + (a1 <<< 16) * nn + a2 * c2 + a3 * c3;
    return acc[47:32];
  endfunction

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: sample=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic writeWord(logic [3:0] addr, logic [15:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = addr; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic loadCoefs(logic [15:0] a0, logic [31:0] a1,
                           logic [47:0] a2, logic [47:0] a3);
    writeWord(4'd0, a0);
    writeWord(4'd1, a1[15:0]);  writeWord(4'd2, a1[31:16]);
    writeWord(4'd3, a2[15:0]);  writeWord(4'd4, a2[31:16]); writeWord(4'd5, a2[47:32]);
    writeWord(4'd6, a3[15:0]);  writeWord(4'd7, a3[31:16]); writeWord(4'd8, a3[47:32]);
  endtask

  task automatic fire();
    @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  // Checks the curve from step 0 onward; call right after fire().
  task automatic sweep(string req, logic [15:0] a0, logic [31:0] a1,
                       logic [47:0] a2, logic [47:0] a3, int len);
    for (int n = 0; n < len; n++) begin
      @(negedge clk);
      check(req, sample, expSample(longint'($signed(a0)), longint'($signed(a1)),
                                   longint'($signed(a2)), longint'($signed(a3)), n));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", sample, 16'h0000);
    rstN = 1'b1;
    fire();
    sweep("R1 empty bank", 16'h0, 32'h0, 48'h0, 48'h0, 8);

    // R5 R6 constant, then fractional ramps and curves
    loadCoefs(16'h1234, 32'h0, 48'h0, 48'h0);
    fire(); sweep("R5 constant", 16'h1234, 32'h0, 48'h0, 48'h0, 16);

    loadCoefs(16'hF000, 32'h0000_8000, 48'h0, 48'h0);
    fire(); sweep("R6 half-LSB ramp", 16'hF000, 32'h0000_8000, 48'h0, 48'h0, SWEEP);

    loadCoefs(16'h0000, 32'hFFFF_0000, 48'h0000_0200_0000, 48'h0);
    fire(); sweep("R6 quadratic", 16'h0000, 32'hFFFF_0000, 48'h0000_0200_0000, 48'h0, SWEEP);

    loadCoefs(16'h0100, 32'h0003_4000, 48'hFFFF_FF00_0000, 48'h0000_0010_0000);
    fire(); sweep("R6 cubic", 16'h0100, 32'h0003_4000, 48'hFFFF_FF00_0000,
                  48'h0000_0010_0000, SWEEP);

    // R4 writes without trigger leave the cubic-free constant running
    loadCoefs(16'h1234, 32'h0, 48'h0, 48'h0);
    fire(); sweep("R4 baseline", 16'h1234, 32'h0, 48'h0, 48'h0, 2);
    writeWord(4'd0, 16'h5555); check("R4 after a0 write", sample, 16'h1234);
    writeWord(4'd2, 16'h0007); check("R4 after a1 write", sample, 16'h1234);
    writeWord(4'd8, 16'h0001); check("R4 after a3 write", sample, 16'h1234);
    repeat (4) begin @(negedge clk); check("R4 hold", sample, 16'h1234); end

    // R7 wrap at full scale
    loadCoefs(16'h7FF0, 32'h0001_0000, 48'h0, 48'h0);
    fire(); sweep("R7 wrap", 16'h7FF0, 32'h0001_0000, 48'h0, 48'h0, 24);
    loadCoefs(16'h0000, 32'h0, 48'h0, 48'h0001_0000_0000);
    fire(); sweep("R7 cubic wrap", 16'h0000, 32'h0, 48'h0, 48'h0001_0000_0000, SWEEP);

    // R3 ignored indices, then R9 replay of the unchanged bank
    loadCoefs(16'hF000, 32'h0000_8000, 48'h0, 48'h0);
    fire(); sweep("R3 before", 16'hF000, 32'h0000_8000, 48'h0, 48'h0, 4);
    for (int a = 9; a < 16; a++) writeWord(4'(a), 16'hFFFF);
    fire(); sweep("R3 R9 replay", 16'hF000, 32'h0000_8000, 48'h0, 48'h0, SWEEP);

    // R8 same-edge write and trigger
    loadCoefs(16'h0100, 32'h0003_4000, 48'hFFFF_FF00_0000, 48'h0000_0010_0000);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'd0; wrData = 16'h4444; trig = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; trig = 1'b0;
    sweep("R8 old bank", 16'h0100, 32'h0003_4000, 48'hFFFF_FF00_0000,
          48'h0000_0010_0000, 20);
    fire(); sweep("R8 R2 new a0", 16'h4444, 32'h0003_4000, 48'hFFFF_FF00_0000,
                  48'h0000_0010_0000, 20);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule